// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore

This block holds a small set of one-bit lock flags that two independent agents, a left port and a right port, use to agree on who may touch a shared resource. Each port has its own select pins, a 3-bit flag index, a 9-bit write bus, a 9-bit read bus and an output-enable for that read bus. Both ports run on one clock. Either port can reach any flag in any cycle.

A port tries to take a flag by writing 0 to it. It then reads the flag back. A read returns all zeros if that port now holds the flag, and all ones if it does not. The port gives the flag up by writing 1. A take request that cannot be granted at once is remembered. It is granted in the cycle after the holder gives the flag up. If both ports ask for a free flag in the same cycle, the left port wins and the right port's request stays remembered.

Driving the memory select and the flag select low together is not a legal access. The block performs nothing for that port and raises a per-port error flag.

Top module: `hsem_pair`

## Requirements
- R1: After reset, no flag is held and no request is remembered. A read of any flag from either port returns 9'h1FF. Both read-enable outputs and both error outputs are low.
- R2: A flag write takes place when flag select is low, memory select is high and write strobe is low. Only data bit 0 counts: 0 asks for the flag and 1 gives it up. Bits 8:1 have no effect.
- R3: A flag read takes place when flag select is low, memory select is high, write strobe is high and read-enable is low. In the cycle after it is sampled, the port's read bus shows its state of the addressed flag on all nine bits, 0 for held and 1 for not held, and its read-enable output is high.
- R4: No flag is ever held by both ports at once.
- R5: A request for a free flag is granted to the requester, and a read in the next cycle returns 0 to it.
- R6: A request for a flag that the other port holds is remembered, not granted. When the holder gives the flag up, the waiting port holds the flag from the next cycle on.
- R7: When both ports ask for the same free flag in one cycle, the left port gets it and the right request is remembered.
- R8: With memory select and flag select both low, the port performs neither a write nor a read. Its error output is high in the next cycle and its read-enable output is low.
- R9: The read-enable output is low in the cycle after a cycle with read-enable input high or flag select high.
- R10: The 3-bit index picks one flag. An operation on one flag leaves every other flag unchanged, and flag 7 works like flag 0.
- R11: A give-up write from a port that is only waiting cancels its remembered request, so it does not get the flag later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_mem_en_n | input | 1 | Left memory select, active low |
| l_flag_en_n | input | 1 | Left flag select, active low |
| l_wr_n | input | 1 | Left write strobe, low = write |
| l_rd_en_n | input | 1 | Left read enable, active low |
| l_addr | input | 3 | Left flag index |
| l_wdata | input | 9 | Left write data |
| l_rdata | output | 9 | Left read data |
| l_rdata_oe | output | 1 | Left read bus drive enable |
| l_conflict | output | 1 | Left illegal select error |
| r_mem_en_n | input | 1 | Right memory select, active low |
| r_flag_en_n | input | 1 | Right flag select, active low |
| r_wr_n | input | 1 | Right write strobe, low = write |
| r_rd_en_n | input | 1 | Right read enable, active low |
| r_addr | input | 3 | Right flag index |
| r_wdata | input | 9 | Right write data |
| r_rdata | output | 9 | Right read data |
| r_rdata_oe | output | 1 | Right read bus drive enable |
| r_conflict | output | 1 | Right illegal select error |

## Verification
Four properties are checked in every cycle: the two ports never hold one flag together, a release from the holder hands the flag to a waiting port, a same-cycle tie goes to the left port, and the read-enable output drops after an illegal or inactive cycle. Other behaviour can only be shown by the bench's scenarios. That covers the returned values seen from each side, the unused upper write bits, the withdrawal of a waiting request, the absence of any effect from an illegal cycle, and flags that do not disturb one another.

// File: rtl/hsem_pkg.sv
package hsem_pkg;
  localparam int SEM_FLAGS = 8;
  localparam int SEM_DW    = 9;

  // Decoded per-port operation for one cycle
  typedef struct packed {
    logic wr;    // flag write this cycle
    logic rd;    // flag read this cycle
    logic err;   // illegal select combination
    logic bit0;  // write data bit 0 (0 = take, 1 = give up)
  } sem_op_t;
endpackage

// File: rtl/hsem_port_dec.sv
module hsem_port_dec
  import hsem_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          mem_en_n,
  input  logic          flag_en_n,
  input  logic          wr_n,
  input  logic          rd_en_n,
  input  logic [DW-1:0] wdata,
  output sem_op_t       op
);
  logic legal_sel;

  always_comb begin
    legal_sel = ~flag_en_n & mem_en_n;
    op.wr     = legal_sel & ~wr_n;
    op.rd     = legal_sel & wr_n & ~rd_en_n;
    op.err    = ~flag_en_n & ~mem_en_n;
    op.bit0   = wdata[0];
  end
endmodule

// File: rtl/hsem_flag_cell.sv
module hsem_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic l_take,
  input  logic l_drop,
  input  logic r_take,
  input  logic r_drop,
  output logic l_owns,
  output logic r_owns
);
  logic l_wait, r_wait;
  logic l_keep, r_keep, l_want, r_want, is_free, l_grant, r_grant;

  always_comb begin
    l_keep  = l_owns & ~l_drop;
    r_keep  = r_owns & ~r_drop;
    l_want  = (l_wait | l_take) & ~l_drop & ~l_owns;
    r_want  = (r_wait | r_take) & ~r_drop & ~r_owns;
    is_free = ~l_keep & ~r_keep;
    l_grant = is_free & l_want;
    r_grant = is_free & r_want & ~l_want;   // left wins a tie
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l_owns <= 1'b0;
      r_owns <= 1'b0;
      l_wait <= 1'b0;
      r_wait <= 1'b0;
    end else begin
      l_owns <= l_keep | l_grant;
      r_owns <= r_keep | r_grant;
      l_wait <= l_want & ~l_grant;
      r_wait <= r_want & ~r_grant;
    end
  end

  AST_NO_DUAL_OWNER: assert property (@(posedge clk) disable iff (rst)
    !(l_owns && r_owns)); // R4
  AST_HANDOFF_TO_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (l_owns && r_wait && l_drop && !r_drop) |=> r_owns); // R6
  AST_HANDOFF_TO_LEFT: assert property (@(posedge clk) disable iff (rst)
    (r_owns && l_wait && r_drop && !l_drop) |=> l_owns); // R6
  AST_TIE_LEFT_WINS: assert property (@(posedge clk) disable iff (rst)
    (!l_owns && !r_owns && !l_wait && !r_wait && l_take && r_take)
    |=> (l_owns && !r_owns)); // R7
endmodule

// File: rtl/hsem_rd_port.sv
module hsem_rd_port
  import hsem_pkg::*;
#(
  parameter int NF = 8,
  parameter int DW = 9,
  localparam int AW = $clog2(NF)
) (
  input  logic          clk,
  input  logic          rst,
  input  sem_op_t       op,
  input  logic [AW-1:0] addr,
  input  logic [NF-1:0] owns,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic          conflict
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '1;
      rdata_oe <= 1'b0;
      conflict <= 1'b0;
    end else begin
      rdata_oe <= op.rd;
      conflict <= op.err;
      if (op.rd) rdata <= {DW{~owns[addr]}};
    end
  end
endmodule

// File: rtl/hsem_pair.sv
module hsem_pair
  import hsem_pkg::*;
#(
  parameter int NUM_FLAGS = SEM_FLAGS,
  parameter int DATA_W    = SEM_DW,
  localparam int AW = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_mem_en_n,
  input  logic              l_flag_en_n,
  input  logic              l_wr_n,
  input  logic              l_rd_en_n,
  input  logic [AW-1:0]     l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rdata_oe,
  output logic              l_conflict,
  input  logic              r_mem_en_n,
  input  logic              r_flag_en_n,
  input  logic              r_wr_n,
  input  logic              r_rd_en_n,
  input  logic [AW-1:0]     r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rdata_oe,
  output logic              r_conflict
);
  sem_op_t l_op, r_op;
  logic [NUM_FLAGS-1:0] l_owns, r_owns;

  hsem_port_dec #(.DW(DATA_W)) l_dec_i (
    .mem_en_n(l_mem_en_n), .flag_en_n(l_flag_en_n), .wr_n(l_wr_n),
    .rd_en_n(l_rd_en_n), .wdata(l_wdata), .op(l_op));

  hsem_port_dec #(.DW(DATA_W)) r_dec_i (
    .mem_en_n(r_mem_en_n), .flag_en_n(r_flag_en_n), .wr_n(r_wr_n),
    .rd_en_n(r_rd_en_n), .wdata(r_wdata), .op(r_op));

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic l_hit, r_hit;
    assign l_hit = l_op.wr && (l_addr == AW'(i));
    assign r_hit = r_op.wr && (r_addr == AW'(i));
    hsem_flag_cell cell_i (
      .clk(clk), .rst(rst),
      .l_take(l_hit & ~l_op.bit0), .l_drop(l_hit & l_op.bit0),
      .r_take(r_hit & ~r_op.bit0), .r_drop(r_hit & r_op.bit0),
      .l_owns(l_owns[i]), .r_owns(r_owns[i]));
  end

  hsem_rd_port #(.NF(NUM_FLAGS), .DW(DATA_W)) l_rd_i (
    .clk(clk), .rst(rst), .op(l_op), .addr(l_addr), .owns(l_owns),
    .rdata(l_rdata), .rdata_oe(l_rdata_oe), .conflict(l_conflict));

  hsem_rd_port #(.NF(NUM_FLAGS), .DW(DATA_W)) r_rd_i (
    .clk(clk), .rst(rst), .op(r_op), .addr(r_addr), .owns(r_owns),
    .rdata(r_rdata), .rdata_oe(r_rdata_oe), .conflict(r_conflict));

  AST_ILLEGAL_LEFT: assert property (@(posedge clk) disable iff (rst)
    (!l_mem_en_n && !l_flag_en_n) |=> (l_conflict && !l_rdata_oe)); // R8
  AST_ILLEGAL_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (!r_mem_en_n && !r_flag_en_n) |=> (r_conflict && !r_rdata_oe)); // R8
  AST_OE_IDLE_LEFT: assert property (@(posedge clk) disable iff (rst)
    (l_rd_en_n || l_flag_en_n) |=> !l_rdata_oe); // R9
  AST_OE_IDLE_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (r_rd_en_n || r_flag_en_n) |=> !r_rdata_oe); // R9
endmodule

// File: tb/hsem_pair_tb.sv
module hsem_pair_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       l_mem_en_n, l_flag_en_n, l_wr_n, l_rd_en_n;
  logic [2:0] l_addr;
  logic [8:0] l_wdata, l_rdata;
  logic       l_rdata_oe, l_conflict;
  logic       r_mem_en_n, r_flag_en_n, r_wr_n, r_rd_en_n;
  logic [2:0] r_addr;
  logic [8:0] r_wdata, r_rdata;
  logic       r_rdata_oe, r_conflict;

  hsem_pair dut_i (.*);

  int errors = 0;
  int checks = 0;

  // Vector: [7] port (0 left, 1 right), [6] read, [5:3] index, [2] write bit0, [1] expected read bit
  localparam int NV = 16;
  localparam logic [7:0] VEC [NV] = '{
    8'b0_0_000_0_0_0, // left takes 0 (R5)
    8'b0_1_000_0_0_0, // left reads 0 -> held
    8'b1_1_000_0_1_0, // right reads 0 -> not held
    8'b1_0_000_0_0_0, // right asks for 0, waits (R6)
    8'b1_1_000_0_1_0, // right still not holder
    8'b0_0_000_1_0_0, // left gives up 0
    8'b1_1_000_0_0_0, // right now holds 0 (R6)
    8'b0_1_000_0_1_0, // left not holder
    8'b1_0_011_0_0_0, // right takes 3 (R10)
    8'b0_1_011_0_1_0,
    8'b1_1_011_0_0_0,
    8'b1_0_000_1_0_0, // right gives up 0
    8'b0_1_000_0_1_0,
    8'b1_0_111_0_0_0, // right takes 7
    8'b1_1_111_0_0_0,
    8'b0_1_111_0_1_0
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    l_mem_en_n = 1; l_flag_en_n = 1; l_wr_n = 1; l_rd_en_n = 1; l_addr = 0; l_wdata = 0;
    r_mem_en_n = 1; r_flag_en_n = 1; r_wr_n = 1; r_rd_en_n = 1; r_addr = 0; r_wdata = 0;
  endtask

  // Drive one op for one cycle on a port; returns at the following negedge.
  task automatic op(input logic rp, input logic rd, input logic [2:0] a, input logic [8:0] d);
    idle_all();
    if (!rp) begin
      l_flag_en_n = 0; l_wr_n = rd; l_rd_en_n = ~rd; l_addr = a; l_wdata = d;
    end else begin
      r_flag_en_n = 0; r_wr_n = rd; r_rd_en_n = ~rd; r_addr = a; r_wdata = d;
    end
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic rp, input logic [2:0] a, input logic e, input string req);
    op(rp, 1'b1, a, 9'h0);
    check(req, rp ? r_rdata : l_rdata, {9{e}});
    check(req, {8'h0, rp ? r_rdata_oe : l_rdata_oe}, 9'h1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    idle_all();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 oe/err", {5'h0, l_rdata_oe, l_conflict, r_rdata_oe, r_conflict}, 9'h0);
    for (int i = 0; i < 8; i++) begin
      rd_chk(1'b0, 3'(i), 1'b1, "R1 left reset read");
      rd_chk(1'b1, 3'(i), 1'b1, "R1 right reset read");
    end

    // Vector walk: R3 R5 R6 R10
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][6]) rd_chk(VEC[v][7], VEC[v][5:3], VEC[v][1], "R3/R5/R6/R10 vector read");
      else op(VEC[v][7], 1'b0, VEC[v][5:3], {8'h0, VEC[v][2]});
    end
    op(1'b1, 1'b0, 3'd3, 9'h1);
    op(1'b1, 1'b0, 3'd7, 9'h1);
    rd_chk(1'b0, 3'd3, 1'b1, "R10 left reads 3 after release");

    // R2: upper write bits ignored
    op(1'b0, 1'b0, 3'd1, 9'h1FE);
    rd_chk(1'b0, 3'd1, 1'b0, "R2 take with upper bits set");
    op(1'b0, 1'b0, 3'd1, 9'h001);
    rd_chk(1'b0, 3'd1, 1'b1, "R2 release bit0 only");
    op(1'b0, 1'b0, 3'd1, 9'h0FE);
    rd_chk(1'b1, 3'd1, 1'b1, "R2 right sees left hold");
    op(1'b0, 1'b0, 3'd1, 9'h1FF);

    // R8: illegal select, no write takes place
    idle_all();
    l_mem_en_n = 0; l_flag_en_n = 0; l_wr_n = 0; l_addr = 3'd2; l_wdata = 9'h0;
    @(negedge clk);
    check("R8 conflict flag", {7'h0, l_conflict, l_rdata_oe}, 9'h2);
    rd_chk(1'b1, 3'd2, 1'b1, "R8 no take by illegal cycle");
    rd_chk(1'b0, 3'd2, 1'b1, "R8 left not holder");
    idle_all();
    l_mem_en_n = 0; l_flag_en_n = 0; l_rd_en_n = 0;
    @(negedge clk);
    check("R8 illegal read no oe", {8'h0, l_rdata_oe}, 9'h0);

    // R9: read-enable input high, then deselected
    idle_all();
    l_flag_en_n = 0; l_wr_n = 1; l_rd_en_n = 1;
    @(negedge clk);
    check("R9 oe low with read-enable high", {8'h0, l_rdata_oe}, 9'h0);
    rd_chk(1'b1, 3'd0, 1'b1, "R9 right read sets oe");
    idle_all();
    r_rd_en_n = 0;
    @(negedge clk);
    check("R9 oe low when deselected", {8'h0, r_rdata_oe}, 9'h0);

    // R7: same-cycle take on free flag 4
    idle_all();
    l_flag_en_n = 0; l_wr_n = 0; l_addr = 3'd4;
    r_flag_en_n = 0; r_wr_n = 0; r_addr = 3'd4;
    @(negedge clk);
    rd_chk(1'b0, 3'd4, 1'b0, "R7 left wins tie");
    rd_chk(1'b1, 3'd4, 1'b1, "R7 right waits");
    op(1'b0, 1'b0, 3'd4, 9'h1);
    rd_chk(1'b1, 3'd4, 1'b0, "R7 right granted after release");
    op(1'b1, 1'b0, 3'd4, 9'h1);

    // R11: waiting port withdraws
    op(1'b0, 1'b0, 3'd5, 9'h0);
    op(1'b1, 1'b0, 3'd5, 9'h0);
    op(1'b1, 1'b0, 3'd5, 9'h1);
    op(1'b0, 1'b0, 3'd5, 9'h1);
    idle_all();
    @(negedge clk);
    rd_chk(1'b1, 3'd5, 1'b1, "R11 withdrawn request not granted");
    rd_chk(1'b0, 3'd5, 1'b1, "R11 flag free");

    finish_run();
  end
endmodule